// File: doc/BRIEF.md
# Synchronous Up-Counter with Registered Look-Ahead Carry

This block is a wide synchronous binary up-counter that keeps its clock rate independent of its width. Its count splits in two. A narrow low field of `LOW_W` bits (three by default) increments on every enabled edge, and its "all ones" term is a small AND. Each bit in the upper field toggles from a carry prefix held in registers. A prefix bit means "every upper bit below this position is one".

The prefix registers reload from a plain AND chain over the upper bits on every enabled edge where the low field is not all ones. They freeze on the enabled edge where the low field is all ones. That is the only edge on which the upper bits may toggle. The long AND chain therefore has up to `2**LOW_W - 1` count periods to settle before its registered result is used.

Every count bit and the wrap strobe come straight from registers, and all of them change together on the rising clock edge. Users attach the counter to a clock, a synchronous reset and a count enable. They read the count, and they use the wrap strobe to cascade or to mark the end of a period.

Top module: `pcc_counter`

## Requirements
- R1: On each rising edge with `rst` low and `en` high, `count` becomes its previous value plus one, modulo 2**WIDTH.
- R2: On an edge with `rst` low and `en` low, `count` keeps its value and `wrap_o` is low after that edge.
- R3: On an edge with `rst` high, `count` becomes zero and `wrap_o` becomes low, whatever `en` is. Reset takes priority over enable.
- R4: When the count is all ones and an enabled edge arrives, the count becomes all zeros.
- R5: `wrap_o` is high for exactly the one cycle that follows the enabled edge taking `count` from all ones to zero. It is low in every other cycle.
- R6: The bits at positions LOW_W and above change only on enabled edges where bits LOW_W-1..0 were all ones (value 7 for LOW_W = 3).
- R7: After a reset at an arbitrary count, the registered carries match the new zero count. Counting from there gives the same result as from power-up.
- R8: If the enable is held low while the low field reads all ones, the frozen carries stay valid for any stall length. The first enabled edge afterwards carries correctly into the upper bits.
- R9: With WIDTH = 4, where the upper field is bit 3 alone, R1 through R6 hold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, active high |
| count | output | WIDTH | Registered count value |
| wrap_o | output | 1 | One-cycle strobe after the all-ones to zero step |

## Verification
A stale or wrong carry-prefix register is never visible in the cycle where it goes wrong. It shows up on the next enabled edge where the low field is all ones. At that edge, one or more upper bits toggle when they should not, or stay put when they should toggle, so `count` departs from the reference within at most 2**LOW_W enabled edges. A wrong top prefix bit shows as a missing or stray `wrap_o` pulse, at the latest on the next pass through all ones. The bench therefore compares every cycle against a reference model. It also aims traffic at reset in mid-count, at long stalls parked on a low field of all ones, and at full wraps.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  // default width of the fast low field
  localparam int unsigned PCC_LOW_W = 3;

  function automatic int unsigned pcc_up_width(input int unsigned width, input int unsigned low_w);
    return width - low_w;
  endfunction
endpackage

// File: rtl/pcc_low_stage.sv
module pcc_low_stage #(
  parameter int unsigned LOW_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [LOW_W-1:0] low_q,
  output logic             low_full
);
  always_ff @(posedge clk) begin
    if (rst)     low_q <= '0;
    else if (en) low_q <= low_q + 1'b1;
  end

  // short AND: the only combinational carry in the clock-critical path
  assign low_full = &low_q;
endmodule

// File: rtl/pcc_carry_regs.sv
module pcc_carry_regs #(
  parameter int unsigned UP_W = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            low_full,
  input  logic [UP_W-1:0] up_q,
  output logic [UP_W:0]   pre_q
);
  // pre_q[i] : all upper bits below position i are one; pre_q[UP_W] : all upper ones
  localparam logic [UP_W:0] PRE_AT_ZERO = {{UP_W{1'b0}}, 1'b1};

  logic [UP_W:0] chain;

  assign chain[0] = 1'b1;
  generate
    for (genvar i = 1; i <= UP_W; i++) begin : g_chain
      assign chain[i] = chain[i-1] & up_q[i-1];
    end
  endgenerate

  // slow chain: sampled only on enabled edges away from the low-field all-ones state
  always_ff @(posedge clk) begin
    if (rst)                   pre_q <= PRE_AT_ZERO;
    else if (en && !low_full)  pre_q <= chain;
  end
endmodule

// File: rtl/pcc_high_stage.sv
module pcc_high_stage #(
  parameter int unsigned UP_W = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            low_full,
  input  logic [UP_W:0]   pre_q,
  output logic [UP_W-1:0] up_q,
  output logic            wrap_q
);
  logic step;
  logic [UP_W-1:0] toggle;

  assign step   = en & low_full;
  assign toggle = pre_q[UP_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)       up_q <= '0;
    else if (step) up_q <= up_q ^ toggle;
  end

  always_ff @(posedge clk) begin
    if (rst) wrap_q <= 1'b0;
    else     wrap_q <= step & pre_q[UP_W];
  end
endmodule

// File: rtl/pcc_counter.sv
module pcc_counter #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned LOW_W = pcc_pkg::PCC_LOW_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [WIDTH-1:0] count,
  output logic             wrap_o
);
  localparam int unsigned UP_W = pcc_pkg::pcc_up_width(WIDTH, LOW_W);

  logic [LOW_W-1:0] low_q;
  logic             low_full;
  logic [UP_W:0]    pre_q;
  logic [UP_W-1:0]  up_q;

  pcc_low_stage #(.LOW_W(LOW_W)) low_i (
    .clk(clk), .rst(rst), .en(en), .low_q(low_q), .low_full(low_full)
  );

  pcc_carry_regs #(.UP_W(UP_W)) carry_i (
    .clk(clk), .rst(rst), .en(en), .low_full(low_full), .up_q(up_q), .pre_q(pre_q)
  );

  pcc_high_stage #(.UP_W(UP_W)) high_i (
    .clk(clk), .rst(rst), .en(en), .low_full(low_full), .pre_q(pre_q),
    .up_q(up_q), .wrap_q(wrap_o)
  );

  assign count = {up_q, low_q};
endmodule

// File: rtl/pcc_counter_chk.sv
module pcc_counter_chk #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned LOW_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [WIDTH-1:0] count,
  input logic             wrap_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  a_r1_increment: assert property (@(posedge clk) disable iff (rst)
    en |=> (count == $past(count) + ONE));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(count) && !wrap_o));

  a_r3_reset: assert property (@(posedge clk)
    rst |=> (count == '0 && !wrap_o));

  // R4 / R5: the strobe follows an enabled step out of all ones
  a_r5_wrap_set: assert property (@(posedge clk) disable iff (rst)
    (en && (&count)) |=> (wrap_o && count == '0));

  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> (count == '0));

  a_r5_single: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> !wrap_o);

  a_r6_upper_still: assert property (@(posedge clk) disable iff (rst)
    (en && !(&count[LOW_W-1:0])) |=> $stable(count[WIDTH-1:LOW_W]));
endmodule

bind pcc_counter pcc_counter_chk #(.WIDTH(WIDTH), .LOW_W(LOW_W)) chk_i (
  .clk(clk), .rst(rst), .en(en), .count(count), .wrap_o(wrap_o)
);

// File: tb/pcc_counter_tb_top.sv
module pcc_counter_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [15:0] cnt16;
  logic        wrap16;
  logic [3:0]  cnt4;
  logic        wrap4;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [15:0] m16 = '0;
  logic [3:0]  m4  = '0;
  logic        w16 = 1'b0;
  logic        w4  = 1'b0;

  always #2.5 clk = ~clk;

  pcc_counter #(.WIDTH(16)) dut_i (
    .clk(clk), .rst(rst), .en(en), .count(cnt16), .wrap_o(wrap16)
  );

  pcc_counter #(.WIDTH(4)) dut4_i (
    .clk(clk), .rst(rst), .en(en), .count(cnt4), .wrap_o(wrap4)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_for(input logic r, input logic e, input logic [15:0] prev);
    if (r)               return "R3";
    if (!e)              return "R2";
    if (&prev)           return "R4";
    if (&prev[2:0])      return "R6";
    return "R1";
  endfunction

  // called at a negedge: drive, pass one rising edge, update model, compare
  task automatic step(input logic r, input logic e);
    string t;
    t = tag_for(r, e, m16);
    rst = r;
    en  = e;
    @(negedge clk);
    if (r) begin
      m16 = '0; m4 = '0; w16 = 1'b0; w4 = 1'b0;
    end else if (e) begin
      w16 = &m16; w4 = &m4;
      m16 = m16 + 16'd1; m4 = m4 + 4'd1;
    end else begin
      w16 = 1'b0; w4 = 1'b0;
    end
    chk(cnt16 == m16, t, cnt16, m16);
    chk(wrap16 == w16, "R5", wrap16, w16);
    chk(cnt4 == m4, "R9", cnt4, m4);
    chk(wrap4 == w4, "R9", wrap4, w4);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // reset state, including reset with enable high (R3)
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    chk(cnt16 == 16'h0 && !wrap16, "R3", cnt16, 0);

    // one full wrap of the wide counter, many of the narrow one (R1 R4 R5 R9)
    for (int i = 0; i < 65536; i++) step(1'b0, 1'b1);
    chk(cnt16 == 16'h0 && wrap16, "R4", cnt16, 0);

    // R8: park on low field all ones below an upper carry, then stall
    while (m16 != 16'h00FF) step(1'b0, 1'b1);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    chk(cnt16 == 16'h0100, "R8", cnt16, 16'h0100);

    // random mix of enable and occasional reset
    for (int i = 0; i < 20000; i++) begin
      step(($urandom % 700) == 0, ($urandom % 4) != 0);
    end

    // R7: reset with many upper ones set, then count past several carries
    while (m16 != 16'h0FF5) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1);
    chk(cnt16 == 16'd300, "R7", cnt16, 300);

    // second wrap of the wide counter with the enable dropping now and then
    while (m16 != 16'hFFF0) step(1'b0, ($urandom % 16) != 0);
    while (m16 != 16'hFFFF) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    chk(cnt16 == 16'hFFFF && !wrap16, "R2", cnt16, 16'hFFFF);
    step(1'b0, 1'b1);
    chk(cnt16 == 16'h0 && wrap16, "R5", wrap16, 1);
    step(1'b0, 1'b1);
    chk(!wrap16, "R5", wrap16, 0);

    done = 1'b1;
    finish_run();
  end
endmodule